// File: doc/BRIEF.md
# Memory Pattern Test Engine

This block exercises a memory region through a single request/response port and checks every word that comes back against a pattern it generates itself. A run is described by a base address, the offset of the last word, a pattern choice, a loop exponent and an operation choice. The operation is either a pure read-check of data already in memory, or a write pass followed by a read-check pass over the same words.

Every pass visits words `0` to `span_words` in order and repeats that visit `2^log2_loops` times. The pattern restarts at word 0 on every visit. Three generators are available: a pseudo-random LFSR sequence, a crosstalk sequence, and a byte-arithmetic sequence with inversion. When the byte-arithmetic sequence is used with write-then-read, the engine writes the complement of each word back right after reading it. Each later visit then expects the flipped data.

The engine raises a completion flag when it finishes. It also reports a 32-bit error word, in which each bit is the OR of the mismatches seen on that data bit during the run.

Top module: `mem_pattern_engine`

## Requirements
- R1: An accepted `start` (in IDLE or DONE) enters a one-cycle CLEAR state. In the cycle after `start`, `err_word` is 0, `cmp_done` is 0 and `mem_req` is 0.
- R2: `pat_sel` encoding: 2'b00 selects LFSR, 2'b01 selects byte-arithmetic, 2'b10 selects crosstalk. 2'b11 is rejected like R3.
- R3: A `start` with `log2_loops` above 15 is rejected. `cfg_reject` is 1 in the following cycle, no request is issued, and `cmp_done` and `err_word` keep their values.
- R4: LFSR word k: word 0 is the seed `{base_addr zero-extended} | 1`. Each next word is `(w >> 1) ^ (w[0] ? 32'h80200003 : 0)`.
- R5: Crosstalk word k is `1 << ((k/2) mod 32)` for even k and the complement of that value for odd k.
- R6: Byte-arithmetic word k is the byte `8'h11 + k*8'h0D` replicated four times, inverted when k is odd.
- R7: In write-then-read mode, the write pass issues `(span_words+1)*2^log2_loops` writes to `base_addr+k` before any read. The read pass then issues the same number of reads.
- R8: With byte-arithmetic and write-then-read, every read is followed by a write of the complement of the expected word to the same address. On odd visits the expected word is the complement of the R6 word. A single visit therefore leaves memory inverted, and two visits leave it as in R6.
- R9: Read-check mode issues no writes, for every pattern.
- R10: `err_word` is the bitwise OR of `rdata ^ expected` over all reads of the run, so it is 0 when every read matches.
- R11: `cmp_done` goes high at the end of a run and stays high, with `mem_req` low, until the next accepted start.
- R12: While `mem_rdy` is low, a pending request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled with the configuration |
| base_addr | input | ADDR_W | First word address; also seeds the LFSR |
| span_words | input | ADDR_W | Offset of the last word in a visit |
| pat_sel | input | 2 | Pattern select (R2) |
| log2_loops | input | 5 | Visits per pass as a power of two |
| wr_then_rd | input | 1 | 1: write then read-check, 0: read-check only |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdy | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | DATA_W | Read data |
| cmp_done | output | 1 | Compare complete |
| err_word | output | DATA_W | Accumulated per-bit mismatch flags |
| cfg_reject | output | 1 | One-cycle flag for a rejected start |

## Verification
The bench builds the engine with its default parameters: a 16-bit address and a 32-bit data word. This width puts the full walking-one cycle and the 32-bit LFSR within reach. Spans of 8 to 40 words, with loop exponents of 0 to 2, keep every run short. They still cover the crosstalk walk past its 16th position, the odd/even visit parity of the write-back, and runs against a memory model that stalls every other cycle. The upper end of the 5-bit loop exponent is reached only as a rejected value (16).

// File: rtl/mpe_pkg.sv
package mpe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CLEAR, ST_WRITE, ST_READ, ST_WBACK, ST_DONE
    } mpe_state_e;

    typedef enum logic [1:0] {
        PAT_LFSR  = 2'b00,
        PAT_BYTE  = 2'b01,
        PAT_XTALK = 2'b10,
        PAT_NONE  = 2'b11
    } mpe_pat_e;

    localparam logic [7:0] BYTE_INIT = 8'h11;
    localparam logic [7:0] BYTE_STEP = 8'h0D;
    localparam int         MAX_LOG2  = 15;
endpackage

// File: rtl/mpe_pattern_gen.sv
module mpe_pattern_gen
    import mpe_pkg::*;
#(
    parameter int              DATA_W    = 32,
    parameter logic [DATA_W-1:0] LFSR_TAPS = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  mpe_pat_e          sel,
    input  logic [DATA_W-1:0] seed,
    output logic [DATA_W-1:0] pat
);
    localparam int POS_W = $clog2(DATA_W);
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] lfsr_q;
    logic [7:0]        byte_q;
    logic [POS_W-1:0]  pos_q;
    logic              odd_q;
    logic [DATA_W-1:0] walk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= '0;
            byte_q <= '0;
            pos_q  <= '0;
            odd_q  <= 1'b0;
        end else if (restart) begin
            lfsr_q <= seed;
            byte_q <= BYTE_INIT;
            pos_q  <= '0;
            odd_q  <= 1'b0;
        end else if (step) begin
            lfsr_q <= {1'b0, lfsr_q[DATA_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);
            byte_q <= byte_q + BYTE_STEP;
            odd_q  <= ~odd_q;
            if (odd_q) pos_q <= pos_q + 1'b1;
        end
    end

    always_comb begin
        walk        = '0;
        walk[pos_q] = 1'b1;
        unique case (sel)
            PAT_LFSR:  pat = lfsr_q;
            PAT_BYTE:  pat = {BYTES{byte_q}} ^ {DATA_W{odd_q}};
            PAT_XTALK: pat = odd_q ? ~walk : walk;
            default:   pat = '0;
        endcase
    end
endmodule

// File: rtl/mpe_err_acc.sv
module mpe_err_acc #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expected,
    output logic [DATA_W-1:0] err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      err <= '0;
        else if (clear)  err <= '0;
        else if (sample) err <= err | (rdata ^ expected);
    end
endmodule

// File: rtl/mem_pattern_engine.sv
module mem_pattern_engine
    import mpe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] span_words,
    input  logic [1:0]        pat_sel,
    input  logic [4:0]        log2_loops,
    input  logic              wr_then_rd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rdy,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cmp_done,
    output logic [DATA_W-1:0] err_word,
    output logic              cfg_reject
);
    localparam int LOOP_W = MAX_LOG2 + 1;

    mpe_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q, span_q, idx_q;
    logic [LOOP_W-1:0] loop_q, loop_last;
    logic [3:0]        log2_q;
    mpe_pat_e          sel_q;
    logic              op_wr_q;
    logic              idle_ok, cfg_bad, accept, refuse;
    logic              wback_mode, last_word, last_loop, adv;
    logic              gen_restart, gen_step;
    logic [DATA_W-1:0] pat, expected;

    assign idle_ok    = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign cfg_bad    = (log2_loops > 5'(MAX_LOG2)) || (pat_sel == PAT_NONE);
    assign accept     = idle_ok && start && !cfg_bad;
    assign refuse     = idle_ok && start && cfg_bad;
    assign wback_mode = (sel_q == PAT_BYTE) && op_wr_q;
    assign loop_last  = (LOOP_W'(1) << log2_q) - LOOP_W'(1);
    assign last_word  = (idx_q == span_q);
    assign last_loop  = (loop_q == loop_last);
    assign adv        = mem_rdy && ((state_q == ST_WRITE) || (state_q == ST_WBACK) ||
                                    (state_q == ST_READ && !wback_mode));
    assign gen_restart = (state_q == ST_CLEAR) || (adv && last_word);
    assign gen_step    = adv && !last_word;
    assign expected    = pat ^ {DATA_W{wback_mode && loop_q[0]}};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cfg_reject <= 1'b0;
        end else begin
            state_q    <= state_d;
            cfg_reject <= refuse;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (accept) state_d = ST_CLEAR;
            ST_CLEAR:         state_d = op_wr_q ? ST_WRITE : ST_READ;
            ST_WRITE:         if (mem_rdy && last_word && last_loop) state_d = ST_READ;
            ST_READ: if (mem_rdy) begin
                if (wback_mode)                  state_d = ST_WBACK;
                else if (last_word && last_loop) state_d = ST_DONE;
            end
            ST_WBACK: if (mem_rdy) state_d = (last_word && last_loop) ? ST_DONE : ST_READ;
            default:          state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_WRITE) || (state_q == ST_READ) || (state_q == ST_WBACK);
        mem_we    = (state_q == ST_WRITE) || (state_q == ST_WBACK);
        mem_addr  = base_q + idx_q;
        mem_wdata = (state_q == ST_WBACK) ? ~expected : pat;
        cmp_done  = (state_q == ST_DONE);
    end

    // run configuration and position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            span_q  <= '0;
            log2_q  <= '0;
            sel_q   <= PAT_LFSR;
            op_wr_q <= 1'b0;
            idx_q   <= '0;
            loop_q  <= '0;
        end else if (accept) begin
            base_q  <= base_addr;
            span_q  <= span_words;
            log2_q  <= log2_loops[3:0];
            sel_q   <= mpe_pat_e'(pat_sel);
            op_wr_q <= wr_then_rd;
            idx_q   <= '0;
            loop_q  <= '0;
        end else if (adv) begin
            if (last_word) begin
                idx_q  <= '0;
                loop_q <= last_loop ? '0 : loop_q + LOOP_W'(1);
            end else begin
                idx_q  <= idx_q + ADDR_W'(1);
            end
        end
    end

    mpe_pattern_gen #(.DATA_W(DATA_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (gen_restart),
        .step    (gen_step),
        .sel     (sel_q),
        .seed    (DATA_W'(base_q) | DATA_W'(1)),
        .pat     (pat)
    );

    mpe_err_acc #(.DATA_W(DATA_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .sample   ((state_q == ST_READ) && mem_rdy),
        .rdata    (mem_rdata),
        .expected (expected),
        .err      (err_word)
    );
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker
    import mpe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        pat_sel,
    input logic [4:0]        log2_loops,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rdy,
    input logic              cmp_done,
    input logic [DATA_W-1:0] err_word,
    input logic              cfg_reject,
    input mpe_state_e        state_q
);
    logic start_ok;
    assign start_ok = start && (log2_loops <= 5'd15) && (pat_sel != 2'b11) &&
                      ((state_q == ST_IDLE) || (state_q == ST_DONE));

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_done |-> !mem_req); // R11

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reject |-> !mem_req); // R3

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (err_word == '0 && !cmp_done && !mem_req)); // R1

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ || state_q == ST_WRITE || state_q == ST_WBACK)
        |=> ((err_word & $past(err_word)) == $past(err_word))); // R10
endmodule

bind mem_pattern_engine mpe_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pat_sel    (pat_sel),
    .log2_loops (log2_loops),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdy    (mem_rdy),
    .cmp_done   (cmp_done),
    .err_word   (err_word),
    .cfg_reject (cfg_reject),
    .state_q    (state_q)
);

// File: tb/tb_mem_pattern_engine.sv
module tb_mem_pattern_engine;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [ADDR_W-1:0] span_words = '0;
    logic [1:0]        pat_sel = '0;
    logic [4:0]        log2_loops = '0;
    logic              wr_then_rd = 1'b0;
    logic              mem_req, mem_we, mem_rdy, cmp_done, cfg_reject;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata, err_word;

    logic              stall_en = 1'b0;
    logic              tick = 1'b0;
    logic [ADDR_W-1:0] inj_addr = '1;
    logic [DATA_W-1:0] inj_mask = '0;
    logic [DATA_W-1:0] mem [0:255];
    int                wr_cnt = 0;
    int                rd_cnt = 0;
    int                checks = 0;
    int                failures = 0;

    always #2.5 clk = ~clk;

    mem_pattern_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

    assign mem_rdy   = mem_req && (!stall_en || tick);
    assign mem_rdata = mem[mem_addr[7:0]] ^ ((mem_addr == inj_addr) ? inj_mask : '0);

    always_ff @(posedge clk) begin
        tick <= ~tick;
        if (mem_req && mem_rdy) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    function automatic logic [31:0] lfsr_at(logic [15:0] base, int k);
        logic [31:0] v = {16'h0, base} | 32'h1;
        for (int i = 0; i < k; i++) v = (v >> 1) ^ (v[0] ? 32'h8020_0003 : 32'h0);
        return v;
    endfunction

    function automatic logic [31:0] xt_at(int k);
        logic [31:0] oh = 32'h1 << ((k / 2) % 32);
        return (k % 2 == 1) ? ~oh : oh;
    endfunction

    function automatic logic [31:0] byte_at(int k);
        logic [7:0] b = 8'h11 + 8'(k * 13);
        return (k % 2 == 1) ? ~{4{b}} : {4{b}};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] b, input logic [15:0] s, input logic [1:0] p,
                       input logic [4:0] l, input logic op);
        int n = 0;
        @(negedge clk);
        base_addr = b; span_words = s; pat_sel = p; log2_loops = l; wr_then_rd = op;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!mem_req && !cmp_done && err_word == '0, "R1 clear cycle",
              {30'h0, mem_req, cmp_done}, 32'h0);
        while (!cmp_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(cmp_done, "R11 run completes", {31'h0, cmp_done}, 32'h1);
    endtask

    task automatic t_reset();
        check(!mem_req && !cmp_done && err_word == '0 && !cfg_reject, "R1 reset state",
              err_word, 32'h0);
    endtask

    task automatic t_lfsr_wr();
        int w0 = wr_cnt, r0 = rd_cnt;
        bit ok = 1'b1;
        run(16'h0010, 16'd15, 2'b00, 5'd1, 1'b1);
        check(err_word == 0, "R10 lfsr clean run", err_word, 32'h0);
        check(wr_cnt - w0 == 32 && rd_cnt - r0 == 32, "R7 access counts",
              32'(wr_cnt - w0), 32'd32);
        for (int k = 0; k < 16; k++) if (mem[8'h10 + k] != lfsr_at(16'h0010, k)) ok = 1'b0;
        check(ok, "R4 lfsr contents", mem[8'h11], lfsr_at(16'h0010, 1));
        check(mem[8'h1F] == lfsr_at(16'h0010, 15), "R4 lfsr last word", mem[8'h1F], lfsr_at(16'h0010, 15));
    endtask

    task automatic t_xtalk_stall();
        bit ok = 1'b1;
        stall_en = 1'b1;
        run(16'h0040, 16'd39, 2'b10, 5'd0, 1'b1);
        stall_en = 1'b0;
        check(err_word == 0, "R12 stalled run clean", err_word, 32'h0);
        for (int k = 0; k < 40; k++) if (mem[8'h40 + k] != xt_at(k)) ok = 1'b0;
        check(ok, "R5 crosstalk contents", mem[8'h40 + 37], xt_at(37));
    endtask

    task automatic t_byte_wback();
        int w0 = wr_cnt;
        bit ok = 1'b1;
        run(16'h0080, 16'd15, 2'b01, 5'd0, 1'b1);
        check(err_word == 0, "R8 single visit clean", err_word, 32'h0);
        check(wr_cnt - w0 == 32, "R8 write-back count", 32'(wr_cnt - w0), 32'd32);
        for (int k = 0; k < 16; k++) if (mem[8'h80 + k] != ~byte_at(k)) ok = 1'b0;
        check(ok, "R8 memory inverted after one visit", mem[8'h80], ~byte_at(0));
        run(16'h0080, 16'd15, 2'b01, 5'd1, 1'b1);
        ok = 1'b1;
        for (int k = 0; k < 16; k++) if (mem[8'h80 + k] != byte_at(k)) ok = 1'b0;
        check(ok, "R6 byte pattern after two visits", mem[8'h83], byte_at(3));
        check(err_word == 0, "R8 two visits clean", err_word, 32'h0);
    endtask

    task automatic t_read_only();
        int w0 = wr_cnt, r0 = rd_cnt;
        run(16'h0080, 16'd15, 2'b01, 5'd2, 1'b0);
        check(wr_cnt == w0, "R9 no writes in read-check", 32'(wr_cnt - w0), 32'd0);
        check(rd_cnt - r0 == 64, "R9 read count", 32'(rd_cnt - r0), 32'd64);
        check(err_word == 0, "R9 read-only byte clean", err_word, 32'h0);
    endtask

    task automatic t_error();
        run(16'h00C0, 16'd7, 2'b00, 5'd0, 1'b1);
        inj_addr = 16'h00C3; inj_mask = 32'h0000_0100;
        run(16'h00C0, 16'd7, 2'b00, 5'd1, 1'b0);
        check(err_word == 32'h0000_0100, "R10 single bit flagged", err_word, 32'h0000_0100);
        inj_addr = 16'h00C7; inj_mask = 32'h8000_0001;
        run(16'h00C0, 16'd7, 2'b00, 5'd0, 1'b0);
        check(err_word == 32'h8000_0001, "R10 error cleared then new bits", err_word, 32'h8000_0001);
        inj_addr = '1; inj_mask = '0;
        run(16'h00C0, 16'd7, 2'b00, 5'd0, 1'b0);
        check(err_word == 0, "R1 error cleared at start", err_word, 32'h0);
    endtask

    task automatic t_reject(input logic [1:0] p, input logic [4:0] l, input string req);
        logic [31:0] e0 = err_word;
        @(negedge clk);
        pat_sel = p; log2_loops = l; wr_then_rd = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_reject && !mem_req, req, {30'h0, cfg_reject, mem_req}, 32'h2);
        repeat (4) @(negedge clk);
        check(cmp_done && !mem_req && err_word == e0, req, err_word, e0);
    endtask

    task automatic t_done_hold();
        repeat (6) @(negedge clk);
        check(cmp_done && !mem_req, "R11 done held", {30'h0, cmp_done, mem_req}, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lfsr_wr();
        t_xtalk_stall();
        t_byte_wback();
        t_read_only();
        t_error();
        t_reject(2'b00, 5'd16, "R3 loop exponent rejected");
        t_reject(2'b11, 5'd1, "R2 pattern code 11 rejected");
        t_done_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule